// File: doc/BRIEF.md
# SAR Converter Conversion Sequencer

This block is the digital control side of a 16-bit successive-approximation converter. Two active-low control lines, a chip select and a read/convert line, are combined. A conversion begins only when both are low, on the falling edge of whichever of the two goes low last. Once a conversion is accepted, the block drives an active-low busy output for a fixed conversion window measured in system clock cycles. At the end of the window it captures the converter's result word into an output holding register and releases busy in the same cycle.

The analog conversion is not modelled. It is replaced by a cycle counter and by a result word supplied from outside on `conv_result`. After each conversion the block enforces an acquisition window before it accepts the next start. A power-down input blocks new conversions, stops one that is running and keeps the held result frozen. The first result captured after reset is flagged as not valid. When internal-clock mode is selected, every accepted start also emits a one-cycle strobe that tells the serial output logic to transmit the previous result.

All control inputs pass through two-flop synchronisers before edge detection. Parameters: `CONV_CYCLES` is the conversion length (default 550 cycles, 2.2 us at 250 MHz). `CYCLE_CYCLES` is the full sample period (default 1000 cycles, 4 us). The acquisition window is the difference between the two.

Top module: `sar_conv_seq`

## Requirements
- R1: A conversion is accepted only when `cs_n` and `rc_n` are both low. The trigger is the moment the second of the two goes low. Either line low on its own starts nothing.
- R2: `busy_n` goes low on the third rising clock edge after the later of the two falling inputs. Two edges are spent in synchronisation and one in edge detection and acceptance.
- R3: `busy_n` stays low for exactly `CONV_CYCLES` clock cycles. On the edge where it returns high, `held_result` takes the value of `conv_result`. In the cycle that follows, `result_latched` is high for exactly one cycle.
- R4: For `CYCLE_CYCLES - CONV_CYCLES` cycles after `busy_n` returns high, a new falling edge of the combined control is ignored and is not remembered.
- R5: A start edge that arrives while `busy_n` is low is ignored. It does not restart the running conversion, does not lengthen it and is not queued for later.
- R6: While `pwrdn` is high, start edges are ignored and `busy_n` stays high. `held_result` and `result_valid` keep their values.
- R7: If `pwrdn` rises during a conversion, the conversion is abandoned. `busy_n` returns high early, `result_latched` does not pulse, and `held_result` is unchanged.
- R8: The first result captured after reset has `result_valid` = 0. Every later captured result sets `result_valid` = 1.
- R9: When `int_clk_sel` is 1, `start_tx` pulses for one cycle in the same cycle that `busy_n` first reads low for an accepted start. When `int_clk_sel` is 0, `start_tx` never pulses.
- R10: During and directly after reset, `busy_n` = 1, `held_result` = 0, `result_valid` = 0, `result_latched` = 0 and `start_tx` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| rc_n | input | 1 | Active-low read/convert line, asynchronous |
| pwrdn | input | 1 | Power-down request, active high, asynchronous |
| int_clk_sel | input | 1 | 1 selects internal-clock transmission mode |
| conv_result | input | DW | Result word the converter core would produce |
| busy_n | output | 1 | Low while a conversion is running |
| held_result | output | DW | Output holding register |
| result_valid | output | 1 | Held result is a valid conversion |
| result_latched | output | 1 | One-cycle strobe after a result is captured |
| start_tx | output | 1 | One-cycle strobe requesting serial transmission |

## Verification
The assertions check these rules on every cycle:
- an accepted start pulls busy low, and busy never falls without one;
- every latch strobe follows a busy-low stretch of exactly the conversion length;
- the holding register changes only with the latch strobe;
- power-down keeps an idle block idle, and an abort never produces a strobe;
- the transmit strobe occurs only together with a falling busy;
- the validity flag is clear on the first capture and set on every later one.

Three behaviours can only be shown by the bench's scenarios. The first is the exact three-edge start latency for each order of the two falling controls. The second is that starts during conversion or acquisition are dropped for good rather than deferred. The third is that captured values match the supplied word across a sweep of data patterns and both transmission modes.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_ACQ  = 2'd2
  } seq_state_e;

  // Both active-low controls asserted: the converter is selected and asked to convert.
  function automatic logic ctl_engaged(input logic cs_low_n, input logic rc_low_n);
    return ~(cs_low_n | rc_low_n);
  endfunction

  // True on the final cycle of a window of len cycles counted from zero.
  function automatic logic last_tick(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sar_sync2.sv
module sar_sync2 #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stable_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= RST_VAL[i];
        stable_q <= RST_VAL[i];
      end else begin
        meta_q   <= async_in[i];
        stable_q <= meta_q;
      end
    end
    assign sync_out[i] = stable_q;
  end

endmodule

// File: rtl/sar_start_det.sv
module sar_start_det
  import sar_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic rc_s,
  output logic start_req
);

  logic engaged;
  logic engaged_q;

  assign engaged = ctl_engaged(cs_s, rc_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) engaged_q <= 1'b0;
    else        engaged_q <= engaged;
  end

  // The ORed active-low control falling is the combined engagement rising.
  assign start_req = engaged & ~engaged_q;

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_seq_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 550,
  parameter int unsigned ACQ_CYCLES  = 450,
  localparam int unsigned CW = $clog2(max_u(CONV_CYCLES, ACQ_CYCLES) + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic pwrdn_s,
  input  logic int_mode_s,
  output logic start_ok,
  output logic latch_evt,
  output logic abort_evt,
  output logic busy_n,
  output logic result_latched,
  output logic start_tx
);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          conv_last;
  logic          acq_last;

  assign conv_last = last_tick(32'(cnt_q), CONV_CYCLES);
  assign acq_last  = last_tick(32'(cnt_q), ACQ_CYCLES);

  assign start_ok  = (state_q == ST_IDLE) & start_req & ~pwrdn_s;
  assign abort_evt = (state_q == ST_CONV) & pwrdn_s;
  assign latch_evt = (state_q == ST_CONV) & ~pwrdn_s & conv_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            state_q <= ST_CONV;
            cnt_q   <= '0;
          end
        end
        ST_CONV: begin
          if (abort_evt) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else if (latch_evt) begin
            state_q <= ST_ACQ;
            cnt_q   <= '0;
          end else begin
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_ACQ: begin
          if (acq_last) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_latched <= 1'b0;
      start_tx       <= 1'b0;
    end else begin
      result_latched <= latch_evt;
      start_tx       <= start_ok & int_mode_s;
    end
  end

  assign busy_n = (state_q != ST_CONV);

endmodule

// File: rtl/sar_hold_reg.sv
module sar_hold_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] held,
  output logic          valid
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= '0;
      valid  <= 1'b0;
      seen_q <= 1'b0;
    end else if (load) begin
      held   <= din;
      valid  <= seen_q;
      seen_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned DW           = 16,
  parameter int unsigned CONV_CYCLES  = 550,
  parameter int unsigned CYCLE_CYCLES = 1000,
  localparam int unsigned ACQ_CYCLES  = CYCLE_CYCLES - CONV_CYCLES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rc_n,
  input  logic          pwrdn,
  input  logic          int_clk_sel,
  input  logic [DW-1:0] conv_result,
  output logic          busy_n,
  output logic [DW-1:0] held_result,
  output logic          result_valid,
  output logic          result_latched,
  output logic          start_tx
);

  // Synchroniser bit order: {mode, power-down, read/convert, chip select}.
  localparam logic [3:0] SYNC_RST = 4'b0011;

  logic [3:0] ctl_s;
  logic       cs_s;
  logic       rc_s;
  logic       pwrdn_s;
  logic       int_mode_s;
  logic       start_req;
  logic       start_ok;
  logic       latch_evt;
  logic       abort_evt;

  sar_sync2 #(.W(4), .RST_VAL(SYNC_RST)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({int_clk_sel, pwrdn, rc_n, cs_n}),
    .sync_out (ctl_s)
  );

  assign cs_s       = ctl_s[0];
  assign rc_s       = ctl_s[1];
  assign pwrdn_s    = ctl_s[2];
  assign int_mode_s = ctl_s[3];

  sar_start_det u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .rc_s      (rc_s),
    .start_req (start_req)
  );

  sar_seq_fsm #(.CONV_CYCLES(CONV_CYCLES), .ACQ_CYCLES(ACQ_CYCLES)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_req      (start_req),
    .pwrdn_s        (pwrdn_s),
    .int_mode_s     (int_mode_s),
    .start_ok       (start_ok),
    .latch_evt      (latch_evt),
    .abort_evt      (abort_evt),
    .busy_n         (busy_n),
    .result_latched (result_latched),
    .start_tx       (start_tx)
  );

  sar_hold_reg #(.DW(DW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (latch_evt),
    .din   (conv_result),
    .held  (held_result),
    .valid (result_valid)
  );

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int unsigned DW          = 16,
  parameter int unsigned CONV_CYCLES = 550
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_n,
  input logic          start_ok,
  input logic          latch_evt,
  input logic          abort_evt,
  input logic          pwrdn_s,
  input logic          result_latched,
  input logic          start_tx,
  input logic          result_valid,
  input logic [DW-1:0] held_result
);

  logic [31:0] low_cnt;
  logic        seen_latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt    <= '0;
      seen_latch <= 1'b0;
    end else begin
      low_cnt    <= busy_n ? 32'd0 : low_cnt + 32'd1;
      if (result_latched) seen_latch <= 1'b1;
    end
  end

  p_busy_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> !busy_n);

  p_fall_needs_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(start_ok));

  p_conv_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_latched |-> (low_cnt == 32'(CONV_CYCLES)));

  p_latch_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> (busy_n && result_latched));

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !result_latched |-> $stable(held_result));

  p_pd_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_s && busy_n) |=> busy_n);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (busy_n && !result_latched));

  p_tx_with_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_tx |-> $fell(busy_n));

  p_first_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (result_latched && !seen_latch) |-> !result_valid);

  p_later_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (result_latched && seen_latch) |-> result_valid);

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy_n         (busy_n),
  .start_ok       (start_ok),
  .latch_evt      (latch_evt),
  .abort_evt      (abort_evt),
  .pwrdn_s        (pwrdn_s),
  .result_latched (result_latched),
  .start_tx       (start_tx),
  .result_valid   (result_valid),
  .held_result    (held_result)
);

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;

  localparam int CONV = 8;
  localparam int CYC  = 14;
  localparam int ACQ  = CYC - CONV;
  localparam int DW   = 16;
  localparam int NWIN = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          rc_n = 1'b1;
  logic          pwrdn = 1'b0;
  logic          int_clk_sel = 1'b0;
  logic [DW-1:0] conv_result = '0;
  logic          busy_n;
  logic [DW-1:0] held_result;
  logic          result_valid;
  logic          result_latched;
  logic          start_tx;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic rec_busy [NWIN];
  logic rec_rl   [NWIN];
  logic rec_tx   [NWIN];

  always #2 clk = ~clk;

  sar_conv_seq #(.DW(DW), .CONV_CYCLES(CONV), .CYCLE_CYCLES(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .pwrdn(pwrdn),
    .int_clk_sel(int_clk_sel), .conv_result(conv_result), .busy_n(busy_n),
    .held_result(held_result), .result_valid(result_valid),
    .result_latched(result_latched), .start_tx(start_tx)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Records n samples, each 1 ns after a rising edge. Index k is after edge k.
  // When mid >= 1, the read/convert line is toggled high at sample mid and low again at mid+2.
  task automatic record(input int n, input int mid, input bit pd_at3);
    for (int k = 0; k < NWIN; k++) begin
      rec_busy[k] = 1'b1; rec_rl[k] = 1'b0; rec_tx[k] = 1'b0;
    end
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #1;
      rec_busy[k] = busy_n;
      rec_rl[k]   = result_latched;
      rec_tx[k]   = start_tx;
      if (mid > 0 && k == mid)     rc_n = 1'b1;
      if (mid > 0 && k == mid + 2) rc_n = 1'b0;
      if (pd_at3 && k == 3)        pwrdn = 1'b1;
    end
  endtask

  function automatic int count_low(input int n);
    int c = 0;
    for (int k = 1; k <= n; k++) if (!rec_busy[k]) c++;
    return c;
  endfunction

  function automatic int first_low(input int n);
    for (int k = 1; k <= n; k++) if (!rec_busy[k]) return k;
    return 0;
  endfunction

  task automatic release_ctl();
    @(negedge clk);
    cs_n = 1'b1; rc_n = 1'b1;
    repeat (ACQ + 6) @(negedge clk);
  endtask

  // order 0: cs first, 1: rc first, 2: both together.
  task automatic run_conv(input int order, input bit mode, input logic [DW-1:0] v,
                          input bit exp_valid);
    int n;
    int rl_cnt;
    int tx_cnt;
    n = CONV + 6;
    int_clk_sel = mode;
    conv_result = v;
    repeat (3) @(negedge clk);
    if (order == 0) begin
      cs_n = 1'b0; repeat (2) @(negedge clk); rc_n = 1'b0;
    end else if (order == 1) begin
      rc_n = 1'b0; repeat (2) @(negedge clk); cs_n = 1'b0;
    end else begin
      cs_n = 1'b0; rc_n = 1'b0;
    end
    record(n, 0, 1'b0);
    chk(first_low(n) == 3, "R2 start latency", first_low(n), 3);
    chk(count_low(n) == CONV, "R3 busy length", count_low(n), CONV);
    rl_cnt = 0; tx_cnt = 0;
    for (int k = 1; k <= n; k++) begin
      if (rec_rl[k]) rl_cnt++;
      if (rec_tx[k]) tx_cnt++;
    end
    chk(rec_rl[CONV + 3] && rl_cnt == 1, "R3 latch strobe", rl_cnt, 1);
    chk(held_result == v, "R3 held value", held_result, v);
    chk(result_valid == exp_valid, "R8 validity", result_valid, exp_valid);
    if (mode) chk(rec_tx[3] && tx_cnt == 1, "R9 tx strobe", tx_cnt, 1);
    else      chk(tx_cnt == 0, "R9 no tx strobe", tx_cnt, 0);
    release_ctl();
  endtask

  initial begin
    logic [DW-1:0] keep;
    bit first;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(busy_n == 1'b1, "R10 busy during reset", busy_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_n == 1'b1 && result_latched == 1'b0 && start_tx == 1'b0,
        "R10 strobes/busy after reset", {busy_n, result_latched, start_tx}, 3'b100);
    chk(held_result == '0 && result_valid == 1'b0, "R10 held/valid after reset",
        held_result, 0);

    // R1: one line low on its own starts nothing
    cs_n = 1'b0;
    record(14, 0, 1'b0);
    chk(count_low(14) == 0, "R1 cs alone", count_low(14), 0);
    release_ctl();
    rc_n = 1'b0;
    record(14, 0, 1'b0);
    chk(count_low(14) == 0, "R1 rc alone", count_low(14), 0);
    release_ctl();

    // R1/R2/R3/R8/R9: sweep of orders, modes and data patterns
    first = 1'b1;
    for (int ord = 0; ord < 3; ord++) begin
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < 4; p++) begin
          logic [DW-1:0] v;
          v = DW'((ord * 8 + m * 4 + p) * 16'h2713 + 16'h0F01) ^ (p[0] ? 16'hFFFF : 16'h0000);
          run_conv(ord, m[0], v, !first);
          first = 1'b0;
        end
      end
    end

    // R5: start edge during busy is neither restarted nor queued
    conv_result = 16'hA5C3;
    @(negedge clk);
    cs_n = 1'b0; rc_n = 1'b0;
    record(NWIN - 1, 5, 1'b0);
    chk(count_low(NWIN - 1) == CONV, "R5 no restart", count_low(NWIN - 1), CONV);
    chk(first_low(NWIN - 1) == 3, "R5 start position", first_low(NWIN - 1), 3);
    release_ctl();

    // R4: start edge during acquisition is dropped
    conv_result = 16'h3C5A;
    @(negedge clk);
    cs_n = 1'b0; rc_n = 1'b0;
    record(NWIN - 1, CONV + 3, 1'b0);
    chk(count_low(NWIN - 1) == CONV, "R4 acquisition ignore", count_low(NWIN - 1), CONV);
    chk(held_result == 16'h3C5A, "R4 held after", held_result, 16'h3C5A);
    release_ctl();

    // R6: power-down blocks starts and freezes the held result
    keep = held_result;
    conv_result = 16'h1234;
    pwrdn = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b0; rc_n = 1'b0;
    record(20, 0, 1'b0);
    chk(count_low(20) == 0, "R6 no start", count_low(20), 0);
    chk(held_result == keep, "R6 held frozen", held_result, keep);
    chk(result_valid == 1'b1, "R6 valid kept", result_valid, 1);
    @(negedge clk);
    cs_n = 1'b1; rc_n = 1'b1;
    pwrdn = 1'b0;
    repeat (ACQ + 6) @(negedge clk);

    // R7: power-down during conversion abandons it
    keep = held_result;
    conv_result = 16'h4321;
    @(negedge clk);
    cs_n = 1'b0; rc_n = 1'b0;
    record(20, 0, 1'b1);
    chk(count_low(20) == 3, "R7 early release", count_low(20), 3);
    begin
      int rl = 0;
      for (int k = 1; k <= 20; k++) if (rec_rl[k]) rl++;
      chk(rl == 0, "R7 no latch strobe", rl, 0);
    end
    chk(held_result == keep, "R7 held unchanged", held_result, keep);
    @(negedge clk);
    cs_n = 1'b1; rc_n = 1'b1;
    pwrdn = 1'b0;
    repeat (ACQ + 6) @(negedge clk);

    // R3/R8: conversion works again after power-down
    run_conv(2, 1'b1, 16'hFEDC, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule